// File: doc/BRIEF.md
# Converter Power-State Sequencer

This block is the digital control core that governs the power state of a serial sampling converter. It is clocked by the serial clock and watches the serial data line while chip select is low. When the block is idle, the first logic 1 it samples marks the start of a control byte. At that edge every circuit section is switched to full power and a conversion begins. Seven more bits follow the start bit, most significant first. The last two of them form a power-down code, which the block keeps until the conversion ends. It then moves the input stage, the comparator and the reference into the state that code selects.

The analog conversion itself is not modelled. A fixed count of serial clock edges stands in for it. A hardware shutdown pin, active low, overrides everything. It aborts a running conversion and switches every section off. When the pin is released, the block returns straight to full operation. The outputs are a drive level for each section and a busy flag. All outputs are registered.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: When the block is not busy, cs_n is low and shdn_n is high, a 1 on sdi at a rising clk edge is a start bit. After that edge busy is 1 and the block is at full power: in_lvl = 2'b11, cmp_lvl = 2'b11, ref_en = 1.
- R2: The start bit is followed by seven control bits, most significant first. The last two are the power-down code, the first of them being the code's high bit. When the conversion ends, the code sets the outputs: 00 gives in_lvl = cmp_lvl = 2'b00 and ref_en = 0; 01 and 10 give in_lvl = cmp_lvl = 2'b01 (reduced) and ref_en = 1; 11 gives in_lvl = cmp_lvl = 2'b11 and ref_en = 1.
- R3: busy stays 1 for exactly 16 clock edges counted from the start edge. It falls after the 15th edge that follows the start edge. While busy is 1, all sections stay at full power whatever code has been received.
- R4: While a conversion runs, sdi values after the control byte have no effect. A new start bit is accepted at the first edge after busy falls, so conversions can run back to back.
- R5: A low shdn_n at a clock edge ends any conversion. After that edge busy = 0 and all sections are off. Start bits are ignored while shdn_n stays low.
- R6: At the first edge at which shdn_n is high again, the block goes to full power (all levels 2'b11, ref_en = 1) with busy = 0.
- R7: While cs_n is high, a 1 on sdi starts nothing, and the outputs keep their values.
- R8: While rst is high, and after it, all outputs are 0 until a start bit or a shutdown release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial control input |
| shdn_n | input | 1 | Hardware shutdown, active low |
| in_lvl | output | 2 | Input stage level: 00 off, 01 reduced, 11 full |
| cmp_lvl | output | 2 | Comparator level: 00 off, 01 reduced, 11 full |
| ref_en | output | 1 | Reference enable |
| busy | output | 1 | Conversion in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit control byte, a 2-bit power-down code and a 16-edge conversion. With these values, every position of the control byte and the full length of a conversion can be checked edge by edge. They also allow back-to-back conversions, a shutdown in the middle of a conversion, and a switch between all four power-down codes within a short run.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  localparam logic [1:0] LVL_OFF  = 2'b00;
  localparam logic [1:0] LVL_LOW  = 2'b01;
  localparam logic [1:0] LVL_FULL = 2'b11;

  typedef enum logic [1:0] {
    PD_SLEEP  = 2'b00,
    PD_QUICK  = 2'b01,
    PD_LEAN   = 2'b10,
    PD_AWAKE  = 2'b11
  } pd_code_t;

  typedef struct packed {
    logic [1:0] in_lvl;
    logic [1:0] cmp_lvl;
    logic       ref_en;
  } pwr_t;

  localparam pwr_t PWR_ALL_OFF  = '{in_lvl: LVL_OFF,  cmp_lvl: LVL_OFF,  ref_en: 1'b0};
  localparam pwr_t PWR_ALL_FULL = '{in_lvl: LVL_FULL, cmp_lvl: LVL_FULL, ref_en: 1'b1};

  function automatic pwr_t pd_to_pwr(input pd_code_t code);
    pwr_t p;
    case (code)
      PD_SLEEP: p = PWR_ALL_OFF;
      PD_QUICK,
      PD_LEAN:  p = '{in_lvl: LVL_LOW, cmp_lvl: LVL_LOW, ref_en: 1'b1};
      default:  p = PWR_ALL_FULL;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int CONV_CYCLES = 16,
  parameter int CTRL_BITS   = 8,
  parameter int PD_BITS     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic               sdi_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [PD_BITS-1:0] pd_o
);

  localparam int CW   = $clog2(CONV_CYCLES);
  localparam int SH_W = CTRL_BITS - 1;

  logic [CW-1:0]   pos_q;
  logic [SH_W-1:0] ctrl_q;
  logic            busy_q;

  assign done_o = busy_q && (pos_q == CW'(CONV_CYCLES - 1));
  assign busy_o = busy_q;
  assign pd_o   = ctrl_q[PD_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      ctrl_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      pos_q  <= CW'(1);
    end else if (busy_q) begin
      if (pos_q < CW'(CTRL_BITS))
        ctrl_q <= {ctrl_q[SH_W-2:0], sdi_i};
      if (done_o) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        pos_q <= pos_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/adc_pwr_state.sv
module adc_pwr_state
  import adc_pwr_pkg::*;
#(
  parameter int PD_BITS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shdn_n_i,
  input  logic               start_i,
  input  logic               done_i,
  input  logic [PD_BITS-1:0] pd_i,
  output pwr_t               pwr_o
);

  pwr_t pwr_q, pwr_d;
  logic hw_off_q;

  always_comb begin
    pwr_d = pwr_q;
    if (!shdn_n_i)     pwr_d = PWR_ALL_OFF;
    else if (start_i)  pwr_d = PWR_ALL_FULL;
    else if (done_i)   pwr_d = pd_to_pwr(pd_code_t'(pd_i[1:0]));
    else if (hw_off_q) pwr_d = PWR_ALL_FULL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q    <= PWR_ALL_OFF;
      hw_off_q <= 1'b0;
    end else begin
      pwr_q    <= pwr_d;
      hw_off_q <= !shdn_n_i;
    end
  end

  assign pwr_o = pwr_q;

endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int CONV_CYCLES = 16,
  parameter int CTRL_BITS   = 8,
  parameter int PD_BITS     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sdi,
  input  logic       shdn_n,
  output logic [1:0] in_lvl,
  output logic [1:0] cmp_lvl,
  output logic       ref_en,
  output logic       busy
);

  logic               seq_busy;
  logic               seq_done;
  logic               start;
  logic [PD_BITS-1:0] pd_code;
  pwr_t               pwr;

  assign start = !cs_n && sdi && !seq_busy && shdn_n;

  adc_pwr_seq #(
    .CONV_CYCLES(CONV_CYCLES),
    .CTRL_BITS  (CTRL_BITS),
    .PD_BITS    (PD_BITS)
  ) seq_i (
    .clk    (clk),
    .rst    (rst),
    .start_i(start),
    .abort_i(!shdn_n),
    .sdi_i  (sdi),
    .busy_o (seq_busy),
    .done_o (seq_done),
    .pd_o   (pd_code)
  );

  adc_pwr_state #(
    .PD_BITS(PD_BITS)
  ) state_i (
    .clk     (clk),
    .rst     (rst),
    .shdn_n_i(shdn_n),
    .start_i (start),
    .done_i  (seq_done),
    .pd_i    (pd_code),
    .pwr_o   (pwr)
  );

  assign in_lvl  = pwr.in_lvl;
  assign cmp_lvl = pwr.cmp_lvl;
  assign ref_en  = pwr.ref_en;
  assign busy    = seq_busy;

endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sdi,
  input logic       shdn_n,
  input logic [1:0] in_lvl,
  input logic [1:0] cmp_lvl,
  input logic       ref_en,
  input logic       busy
);

  // R1
  a_r1_start_wakes: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cs_n && sdi && shdn_n) |=> (busy && in_lvl == 2'b11));

  // R3
  a_r3_full_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (in_lvl == 2'b11 && cmp_lvl == 2'b11 && ref_en));

  // R5
  a_r5_shutdown_off: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (!busy && in_lvl == 2'b00 && cmp_lvl == 2'b00 && !ref_en));

  // R6
  a_r6_shutdown_exit: assert property (@(posedge clk) disable iff (rst)
    ($rose(shdn_n) && !$past(rst)) |=> (in_lvl == 2'b11 && cmp_lvl == 2'b11 && ref_en));

  // R7
  a_r7_deselected_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && cs_n) |=> !busy);

  // R8
  a_r8_reset_off: assert property (@(posedge clk)
    rst |=> (!busy && in_lvl == 2'b00 && cmp_lvl == 2'b00 && !ref_en));

endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .cs_n   (cs_n),
  .sdi    (sdi),
  .shdn_n (shdn_n),
  .in_lvl (in_lvl),
  .cmp_lvl(cmp_lvl),
  .ref_en (ref_en),
  .busy   (busy)
);

// File: tb/adc_pwr_ctrl_tb_top.sv
module adc_pwr_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sdi = 1'b0;
  logic       shdn_n = 1'b1;
  logic [1:0] in_lvl, cmp_lvl;
  logic       ref_en, busy;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  typedef struct {
    logic       b;
    logic [1:0] i;
    logic [1:0] c;
    logic       r;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  adc_pwr_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sdi(sdi), .shdn_n(shdn_n),
    .in_lvl(in_lvl), .cmp_lvl(cmp_lvl), .ref_en(ref_en), .busy(busy)
  );

  task automatic compare(input exp_t e);
    n_checks++;
    if (busy !== e.b || in_lvl !== e.i || cmp_lvl !== e.c || ref_en !== e.r) begin
      n_errors++;
      $display("FAIL %s: got busy=%b in=%b cmp=%b ref=%b, expected busy=%b in=%b cmp=%b ref=%b",
               e.tag, busy, in_lvl, cmp_lvl, ref_en, e.b, e.i, e.c, e.r);
    end
  endtask

  // monitor: compare the state left by each edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) compare(q.pop_front());
  end

  function automatic exp_t mk(input logic b, input logic [1:0] i, input logic [1:0] c,
                              input logic r, input string tag);
    exp_t e;
    e.b = b; e.i = i; e.c = c; e.r = r; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t after_code(input logic [1:0] pd);
    case (pd)
      2'b00:   return mk(1'b0, 2'b00, 2'b00, 1'b0, "R2 code 00");
      2'b01:   return mk(1'b0, 2'b01, 2'b01, 1'b1, "R2 code 01");
      2'b10:   return mk(1'b0, 2'b01, 2'b01, 1'b1, "R2 code 10");
      default: return mk(1'b0, 2'b11, 2'b11, 1'b1, "R2 code 11");
    endcase
  endfunction

  // driver: set inputs for the next edge and queue what that edge must produce
  task automatic step(input logic cs, input logic d, input logic sh, input exp_t e);
    @(negedge clk);
    cs_n = cs; sdi = d; shdn_n = sh;
    q.push_back(e);
  endtask

  task automatic conv(input logic [1:0] pd, input logic [4:0] hi, input int abort_at);
    logic [6:0] ctrl;
    ctrl = {hi, pd};
    step(1'b0, 1'b1, 1'b1, mk(1'b1, 2'b11, 2'b11, 1'b1, "R1 start"));
    for (int k = 1; k < 16; k++) begin
      logic d;
      d = (k <= 7) ? ctrl[7-k] : 1'b1;
      if (k == abort_at) begin
        step(1'b0, d, 1'b0, mk(1'b0, 2'b00, 2'b00, 1'b0, "R5 abort"));
        return;
      end
      if (k < 15)
        step(1'b0, d, 1'b1, mk(1'b1, 2'b11, 2'b11, 1'b1, (k > 7) ? "R4 tail ignored" : "R3 full in byte"));
      else
        step(1'b0, 1'b0, 1'b1, after_code(pd));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(mk(1'b0, 2'b00, 2'b00, 1'b0, "R8 in reset"));
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b1, mk(1'b0, 2'b00, 2'b00, 1'b0, "R8 after reset"));
    repeat (3) step(1'b1, 1'b1, 1'b1, mk(1'b0, 2'b00, 2'b00, 1'b0, "R7 deselected"));
    conv(2'b00, 5'b10110, -1);
    repeat (2) step(1'b0, 1'b0, 1'b1, mk(1'b0, 2'b00, 2'b00, 1'b0, "R2 sleep holds"));
    conv(2'b01, 5'b01101, -1);
    conv(2'b10, 5'b11111, -1);                 // R4 back to back
    conv(2'b11, 5'b00000, -1);
    step(1'b1, 1'b1, 1'b1, mk(1'b0, 2'b11, 2'b11, 1'b1, "R7 deselected awake"));
    conv(2'b01, 5'b10101, 5);
    repeat (2) step(1'b0, 1'b1, 1'b0, mk(1'b0, 2'b00, 2'b00, 1'b0, "R5 start ignored"));
    step(1'b1, 1'b0, 1'b1, mk(1'b0, 2'b11, 2'b11, 1'b1, "R6 exit"));
    conv(2'b00, 5'b11001, -1);
    conv(2'b10, 5'b00110, -1);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got no end, expected run to finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule